// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers one-cycle event pulses from the receive path, the transmit path and the bus/reset logic into a single 32-bit status word. Each event sets its own status bit. The bit stays set until the host reads the status register, and that read returns the word and clears it. Bit 15 is a derived summary. It is high whenever any bit from 25 down to 16 is set, so one test tells software that a serious fault or a reset completion is pending.

The host also programs a 32-bit mask and a one-bit global enable. A level interrupt output is raised while the enable is set and at least one status bit, the summary bit included, is set together with its mask bit. Register access uses a plain strobed bus: an address, a read strobe, a write strobe and a data word. Read data is presented combinationally during the read cycle. Any clearing takes effect at the clock edge that ends the read.

Internally, a small register-select decode classifies each access as SEL_NONE, SEL_STAT, SEL_MASK or SEL_ENAB, using a `unique case`. The classification is chosen fresh on every cycle from the address. Any state may move to any other on the next cycle, and a strobe acts only in the state it selects.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word, the mask and the enable all read as zero, and the interrupt output `irq` is low.
- R2: A pulse on receive event input k (k = 0 to 5: ok, descriptor done, error, early threshold, idle, overrun) sets status bit k. The bit stays set until a clearing read.
- R3: A pulse on transmit event input k (k = 0 to 4: ok, descriptor done, error, idle, underrun) sets status bit 6+k.
- R4: A pulse on fault event input k (k = 0 to 5: target abort, master abort, system error, parity error, receive reset done, transmit reset done) sets status bit 20+k.
- R5: Status bit 15 reads as one exactly when some bit in 25..16 is set. Bits 11..14, 16..19 and 26..31 always read as zero.
- R6: A read at offset 0x10 returns the status word, and all status bits are cleared at the end of that cycle.
- R7: An event that arrives in the same cycle as a clearing read is not lost. The read returns the earlier value, and the bit is set afterwards.
- R8: The mask at offset 0x14 is fully read/write. The enable at offset 0x18 stores only bit 0, and its other bits read as zero.
- R9: `irq` is high exactly when enable bit 0 is one and (status & mask) is non-zero, with the summary bit counted as a status bit.
- R10: A write to offset 0x10 leaves the status word unchanged. Reads of the other offsets do not clear the status word, and an unmapped offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| rx_evt | input | 6 | Receive event pulses |
| tx_evt | input | 5 | Transmit event pulses |
| flt_evt | input | 6 | Bus fault and reset-done event pulses |
| irq | output | 1 | Level interrupt to the host |

## Verification
The hardest case to reach from the ports is an event that lands on the very edge at which a status read clears the register. The bench holds an event input high during the read strobe cycle itself. It then expects the read to miss the event and the next read to show it.

A second awkward case is an interrupt raised only through the summary bit. This needs a mask that has nothing set except bit 15, followed by a fault pulse.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int RX_N     = 6;
    localparam int TX_N     = 5;
    localparam int FLT_N    = 6;
    localparam int RX_LSB   = 0;
    localparam int TX_LSB   = RX_LSB + RX_N;
    localparam int SUM_BIT  = 15;
    localparam int HI_LSB   = 16;
    localparam int HI_MSB   = 25;
    localparam int FLT_LSB  = 20;
    localparam int GAP_W    = HI_LSB - TX_LSB - TX_N + (FLT_LSB - HI_LSB);
    localparam int TOP_W    = REG_W - FLT_LSB - FLT_N;

    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ENAB = 8'h18;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_ENAB
    } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_status_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            OFS_STAT: sel = SEL_STAT;
            OFS_MASK: sel = SEL_MASK;
            OFS_ENAB: sel = SEL_ENAB;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [RX_N-1:0]  rx_evt,
    input  logic [TX_N-1:0]  tx_evt,
    input  logic [FLT_N-1:0] flt_evt,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] stat_view
);
    logic [REG_W-1:0] set_vec;
    logic             summary;

    assign set_vec = {{TOP_W{1'b0}}, flt_evt, {GAP_W{1'b0}}, tx_evt, rx_evt};

    generate
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[b] <= 1'b0;
                end else begin
                    stat_q[b] <= (stat_q[b] & ~clr) | set_vec[b];
                end
            end
        end
    endgenerate

    assign summary = |stat_q[HI_MSB:HI_LSB];

    always_comb begin
        stat_view          = stat_q;
        stat_view[SUM_BIT] = summary;
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic             wr_enab,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q,
    output logic             ie_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            if (wr_enab) ie_q   <= wdata[0];
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        rx_evt,
    input  logic [4:0]        tx_evt,
    input  logic [5:0]        flt_evt,
    output logic              irq
);
    reg_sel_e         sel;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] stat_view;
    logic [REG_W-1:0] mask_q;
    logic             ie_q;
    logic             clr_stat;
    logic             wr_mask;
    logic             wr_enab;

    irq_reg_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign clr_stat = bus_rd && (sel == SEL_STAT);
    assign wr_mask  = bus_wr && (sel == SEL_MASK);
    assign wr_enab  = bus_wr && (sel == SEL_ENAB);

    irq_status_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_stat),
        .rx_evt    (rx_evt),
        .tx_evt    (tx_evt),
        .flt_evt   (flt_evt),
        .stat_q    (stat_q),
        .stat_view (stat_view)
    );

    irq_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_enab (wr_enab),
        .wdata   (bus_wdata),
        .mask_q  (mask_q),
        .ie_q    (ie_q)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT: bus_rdata = stat_view;
            SEL_MASK: bus_rdata = mask_q;
            SEL_ENAB: bus_rdata = {{(REG_W-1){1'b0}}, ie_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ie_q && (|(stat_view & mask_q));
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [5:0]  rx_evt,
    input logic [4:0]  tx_evt,
    input logic [5:0]  flt_evt,
    input logic        irq,
    input logic [31:0] stat_q,
    input logic [31:0] mask_q,
    input logic        ie_q
);
    logic any_evt;
    assign any_evt = (|rx_evt) || (|tx_evt) || (|flt_evt);

    p_rx_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt[0] |=> stat_q[0]);

    p_flt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flt_evt[5] |=> stat_q[25]);

    p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h10) |-> (bus_rdata[15] == (|bus_rdata[25:16])));

    p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h10 && !any_evt) |=> (stat_q == 32'h0));

    p_kept_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h10 && tx_evt[4]) |=> stat_q[10]);

    p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h14) |=> (mask_q == $past(bus_wdata)));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_rd && bus_addr == 8'h10) && !any_evt) |=> $stable(stat_q));
endmodule

bind irq_status_unit irq_status_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_evt    (rx_evt),
    .tx_evt    (tx_evt),
    .flt_evt   (flt_evt),
    .irq       (irq),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .ie_q      (ie_q)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [5:0]  rx_evt = '0;
    logic [4:0]  tx_evt = '0;
    logic [5:0]  flt_evt = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irq_status_unit u_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .flt_evt(flt_evt), .irq(irq)
    );

    // Monitor: every read cycle pops one expected word and compares
    always @(negedge clk) begin
        if (bus_rd) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] r, input logic [4:0] t, input logic [5:0] f);
        @(posedge clk); #1;
        rx_evt = r; tx_evt = t; flt_evt = f;
        @(posedge clk); #1;
        rx_evt = '0; tx_evt = '0; flt_evt = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(8'h10, 32'h0, "R1 status reset");
        rd(8'h14, 32'h0, "R1 mask reset");
        rd(8'h18, 32'h0, "R1 enable reset");
        // R2 receive events, bits 0..5
        pulse(6'b101001, 5'b0, 6'b0);
        rd(8'h14, 32'h0, "R10 mask read leaves status");
        rd(8'h10, 32'h0000_0029, "R2 receive bits");
        rd(8'h10, 32'h0, "R6 cleared after read");
        // R3 transmit events, bits 6..10
        pulse(6'b0, 5'b10110, 6'b0);
        rd(8'h10, 32'h0000_0580, "R3 transmit bits");
        // R4/R5 fault events bits 20..25 and summary bit 15
        pulse(6'b0, 5'b0, 6'b100001);
        rd(8'h10, 32'h0210_8000, "R4 fault bits with R5 summary");
        pulse(6'b111111, 5'b11111, 6'b111111);
        rd(8'h10, 32'h03F0_87FF, "R5 all events, reserved zero");
        // R10 write to status ignored, unmapped offset reads zero
        pulse(6'b000010, 5'b0, 6'b0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R10 unmapped offset");
        rd(8'h10, 32'h0000_0002, "R10 status write ignored");
        // R7 event coincident with clearing read
        pulse(6'b000100, 5'b0, 6'b0);
        @(posedge clk); #1;
        exp_q.push_back(32'h0000_0004); tag_q.push_back("R7 read returns earlier value");
        bus_addr = 8'h10; bus_rd = 1'b1; tx_evt = 5'b10000;
        @(posedge clk); #1;
        bus_rd = 1'b0; tx_evt = '0;
        rd(8'h10, 32'h0000_0400, "R7 coincident event kept");
        // R8 mask and enable storage
        wr(8'h14, 32'hA5A5_5A5A);
        rd(8'h14, 32'hA5A5_5A5A, "R8 mask readback");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0000_0001, "R8 enable bit 0 only");
        // R9 interrupt gating
        wr(8'h14, 32'h0000_0001);
        pulse(6'b000010, 5'b0, 6'b0);
        chk_irq(1'b0, "R9 unmasked bit gives no irq");
        pulse(6'b000001, 5'b0, 6'b0);
        chk_irq(1'b1, "R9 masked bit raises irq");
        wr(8'h18, 32'h0);
        chk_irq(1'b0, "R9 enable off drops irq");
        wr(8'h18, 32'h1);
        chk_irq(1'b1, "R9 enable on restores irq");
        rd(8'h10, 32'h0000_0003, "R6 read before irq drop");
        chk_irq(1'b0, "R9 irq low after clear");
        // R9 via summary bit only
        wr(8'h14, 32'h0000_8000);
        pulse(6'b0, 5'b0, 6'b000100);
        chk_irq(1'b1, "R9 summary raises irq");
        rd(8'h10, 32'h0040_8000, "R4 system error bit");
        chk_irq(1'b0, "R9 summary cleared");
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule